// File: doc/BRIEF.md
# Per-Row Dual-Rate Refresh Scheduler

This block decides, row by row, how often each row of a small memory must be refreshed, and issues the refresh requests. Each row belongs to a refresh class. Every row starts in the fast class, so the system can run at once with no up-front test sweep. The scheduler asks an external checker to verify rows one at a time, against whatever data the rows hold at that moment. A row whose check passes moves to the slow class, whose interval is a whole multiple of the fast interval. A row whose check fails stays fast. Any write to a row cancels what its last check proved.

Time is measured in ticks from an external `tick_i` pulse. The fast interval is `HI_TICKS` ticks and stands for the nominal 64 ms retention budget. The slow interval is `HI_TICKS*LO_MULT` ticks. Each row has its own deadline counter. When several rows fall due together, a fixed-priority pick sends their refreshes out one per cycle. Ticks must be at least `ROWS+2` cycles apart, so that every burst drains before the next tick.

Top module: `dr_refresh_sched`

## Requirements
- R1: After reset every row is in the fast class with a zero deadline count, and `ref_req_o` and `chk_req_o` are low. The first refresh of every row comes `HI_TICKS` ticks after reset.
- R2: A fast-class row is refreshed exactly `HI_TICKS` ticks after its previous refresh. `ref_req_o` pulses one cycle after the clock edge that captured the tick which made the row due.
- R3: A slow-class row is refreshed exactly `HI_TICKS*LO_MULT` ticks after its previous refresh. No row's deadline count ever exceeds its class interval.
- R4: Rows that are due at the same time are refreshed one per cycle, lowest row index first. A row's count restarts at the refresh (at 1 if a tick lands in that same cycle).
- R5: A row enters the slow class only on a passing result (`res_pass_i`=1) for the check outstanding on that row, and only if that row was not written since the check was issued.
- R6: A failing result puts the row in a faulty fast state. The row is not checked again until it is written.
- R7: A write to a slow-class row returns it to the fast class and makes it eligible for a new check. If `HI_TICKS` or more ticks have passed since its last refresh, it is refreshed immediately. Otherwise it is refreshed `HI_TICKS` ticks after its last refresh.
- R8: `chk_req_o` is a one-cycle pulse with `chk_row_o` set to the lowest-indexed row that is fast and unchecked. It is raised only when no check is outstanding, so at most one check is outstanding at a time.
- R9: A write to the row under check, from the issue cycle up to and including the cycle of the result, voids that result. The row stays fast and unchecked and is requested again.
- R10: A result (`res_valid_i`=1) that arrives while no check is outstanding changes no row's class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle time-base pulse |
| wr_valid_i | input | 1 | A row's contents are being rewritten this cycle |
| wr_row_i | input | $clog2(ROWS) | Row being written |
| res_valid_i | input | 1 | Check result for the outstanding check |
| res_pass_i | input | 1 | 1 = row passed with its current data, 0 = failure seen |
| ref_req_o | output | 1 | Refresh request pulse |
| ref_row_o | output | $clog2(ROWS) | Row to refresh |
| chk_req_o | output | 1 | Check request pulse |
| chk_row_o | output | $clog2(ROWS) | Row to check |

## Verification
Two events can meet in one cycle: a write to the row under check and the arrival of that row's check result. The bench drives both in the same cycle, with a pass verdict. The design is correct only if the row stays fast and is requested again. This is judged from the next `chk_row_o` and from that row's later refresh spacing. A second overlap is a write to a slow row whose elapsed count already exceeds the fast interval. Here demotion and an immediate refresh must happen together, and the bench checks that the refresh comes out in the same tick window as the write.

// File: rtl/dr_pkg.sv
package dr_pkg;

  // Refresh class of one row.
  typedef enum logic [1:0] {
    ROW_FRESH  = 2'd0,  // fast rate, content not yet verified
    ROW_FAULTY = 2'd1,  // fast rate, check failed on current content
    ROW_SLOW   = 2'd2   // slow rate, current content verified
  } row_cls_e;

  // Interval in ticks for a row of the given class.
  function automatic int unsigned period_for(input logic slow,
                                             input int unsigned hi,
                                             input int unsigned mult);
    return slow ? hi * mult : hi;
  endfunction

  // Count kept by a row that is pulled back to the fast rate.
  function automatic int unsigned demote_count(input int unsigned elapsed,
                                               input int unsigned hi);
    return (elapsed > hi) ? hi : elapsed;
  endfunction

endpackage

// File: rtl/dr_lowest_pick.sv
module dr_lowest_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dr_row_timer.sv
module dr_row_timer #(
  parameter int HI_TICKS = 64,
  parameter int LO_MULT  = 4,
  parameter int CNT_W    = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic slow_i,
  input  logic demote_i,
  input  logic refresh_i,
  output logic due_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic [31:0]      elapsed;

  assign limit   = CNT_W'(dr_pkg::period_for(slow_i, HI_TICKS, LO_MULT));
  assign elapsed = 32'(cnt_q) + 32'(tick_i);
  assign due_o   = (cnt_q >= limit);

  always_comb begin
    if (refresh_i)     cnt_d = CNT_W'(tick_i);
    else if (demote_i) cnt_d = CNT_W'(dr_pkg::demote_count(elapsed, HI_TICKS));
    else               cnt_d = CNT_W'(elapsed);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  deadline_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R4
  restart_on_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_i && !tick_i |=> cnt_q == '0);
endmodule

// File: rtl/dr_row_class.sv
module dr_row_class
  import dr_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid_i,
  input  logic [IDX_W-1:0] wr_row_i,
  input  logic             res_valid_i,
  input  logic             res_pass_i,
  input  logic             issue_i,
  input  logic [IDX_W-1:0] issue_row_i,
  output logic [ROWS-1:0]  slow_o,
  output logic [ROWS-1:0]  fresh_o,
  output logic [ROWS-1:0]  demote_o,
  output logic             busy_o
);
  logic             busy_q, stale_q;
  logic [IDX_W-1:0] busy_row_q;
  logic             res_take;
  logic             busy_row_written;
  logic             issue_row_written;
  row_cls_e         st_q [ROWS];
  logic [ROWS-1:0]  wr_hit, res_here, promote, fault;

  assign res_take          = res_valid_i && busy_q;
  assign busy_row_written  = wr_valid_i && (wr_row_i == busy_row_q);
  assign issue_row_written = wr_valid_i && (wr_row_i == issue_row_i);
  assign busy_o            = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      busy_row_q <= '0;
      stale_q    <= 1'b0;
    end else if (issue_i) begin
      busy_q     <= 1'b1;
      busy_row_q <= issue_row_i;
      stale_q    <= issue_row_written;
    end else begin
      if (res_take) busy_q <= 1'b0;
      if (busy_q && busy_row_written) stale_q <= 1'b1;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign wr_hit[r]   = wr_valid_i && (wr_row_i == IDX_W'(r));
    assign res_here[r] = res_take && (busy_row_q == IDX_W'(r));
    assign promote[r]  = res_here[r] && res_pass_i && !stale_q && !wr_hit[r];
    assign fault[r]    = res_here[r] && !res_pass_i && !stale_q && !wr_hit[r];

    always_ff @(posedge clk) begin
      if (!rst_n)          st_q[r] <= ROW_FRESH;
      else if (wr_hit[r])  st_q[r] <= ROW_FRESH;
      else if (promote[r]) st_q[r] <= ROW_SLOW;
      else if (fault[r])   st_q[r] <= ROW_FAULTY;
    end

    assign slow_o[r]   = (st_q[r] == ROW_SLOW);
    assign fresh_o[r]  = (st_q[r] == ROW_FRESH);
    assign demote_o[r] = wr_hit[r] && (st_q[r] == ROW_SLOW);

    // R5
    promote_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[r] == ROW_SLOW) |-> $past(res_here[r] && res_pass_i));

    // R6
    fault_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[r] == ROW_FAULTY) |-> $past(res_here[r] && !res_pass_i));

    // R7
    write_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[r] |=> st_q[r] == ROW_FRESH);

    // R9
    void_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_here[r] && (stale_q || wr_hit[r]) |=> st_q[r] == ROW_FRESH);
  end

  // R10
  idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i && !busy_q && !wr_valid_i |=> $stable(slow_o));
endmodule

// File: rtl/dr_refresh_sched.sv
module dr_refresh_sched #(
  parameter int ROWS     = 8,
  parameter int HI_TICKS = 64,
  parameter int LO_MULT  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic                    wr_valid_i,
  input  logic [$clog2(ROWS)-1:0] wr_row_i,
  input  logic                    res_valid_i,
  input  logic                    res_pass_i,
  output logic                    ref_req_o,
  output logic [$clog2(ROWS)-1:0] ref_row_o,
  output logic                    chk_req_o,
  output logic [$clog2(ROWS)-1:0] chk_row_o
);
  localparam int IDX_W = $clog2(ROWS);
  localparam int CNT_W = $clog2(HI_TICKS * LO_MULT + 2);

  logic [ROWS-1:0]  slow_vec, fresh_vec, demote_vec, due_vec, ref_issue_vec;
  logic             busy;
  logic             due_any, fresh_any, chk_issue;
  logic [IDX_W-1:0] due_idx, fresh_idx;
  logic             ref_req_q, chk_req_q;
  logic [IDX_W-1:0] ref_row_q, chk_row_q;

  dr_row_class #(.ROWS(ROWS), .IDX_W(IDX_W)) u_class (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid_i  (wr_valid_i),
    .wr_row_i    (wr_row_i),
    .res_valid_i (res_valid_i),
    .res_pass_i  (res_pass_i),
    .issue_i     (chk_issue),
    .issue_row_i (fresh_idx),
    .slow_o      (slow_vec),
    .fresh_o     (fresh_vec),
    .demote_o    (demote_vec),
    .busy_o      (busy)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_tmr
    dr_row_timer #(.HI_TICKS(HI_TICKS), .LO_MULT(LO_MULT), .CNT_W(CNT_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .slow_i    (slow_vec[r]),
      .demote_i  (demote_vec[r]),
      .refresh_i (ref_issue_vec[r]),
      .due_o     (due_vec[r])
    );
  end

  dr_lowest_pick #(.N(ROWS), .IW(IDX_W)) u_ref_pick (
    .req_i (due_vec),
    .any_o (due_any),
    .idx_o (due_idx)
  );

  dr_lowest_pick #(.N(ROWS), .IW(IDX_W)) u_chk_pick (
    .req_i (fresh_vec),
    .any_o (fresh_any),
    .idx_o (fresh_idx)
  );

  assign ref_issue_vec = due_any ? (ROWS'(1) << due_idx) : '0;
  assign chk_issue     = fresh_any && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_req_q <= 1'b0;
      ref_row_q <= '0;
      chk_req_q <= 1'b0;
      chk_row_q <= '0;
    end else begin
      ref_req_q <= due_any;
      ref_row_q <= due_idx;
      chk_req_q <= chk_issue;
      chk_row_q <= fresh_idx;
    end
  end

  assign ref_req_o = ref_req_q;
  assign ref_row_o = ref_row_q;
  assign chk_req_o = chk_req_q;
  assign chk_row_o = chk_row_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_ord
    logic [ROWS-1:0] below_mask;
    assign below_mask = (ROWS'(1) << r) - ROWS'(1);

    // R4
    lowest_due_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req_q && (ref_row_q == IDX_W'(r)) |->
        $past(due_vec[r]) && (($past(due_vec) & below_mask) == '0));
  end

  // R8
  single_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req_q |=> !chk_req_q);

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !ref_req_q && !chk_req_q);
endmodule

// File: tb/tb_dr_refresh_sched.sv
`timescale 1ns/1ps
module tb_dr_refresh_sched;
  localparam int ROWS = 8;
  localparam int HI   = 4;
  localparam int LMUL = 4;
  localparam int LO   = HI * LMUL;

  localparam logic [1:0] OP_TICKS = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_RES   = 2'd2;
  localparam logic [1:0] OP_WRRES = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] arg;   // tick count or row
    logic       pass;
    logic [7:0] exp;   // expected row under check, 255 = none
  } step_t;

  localparam int NSTEP = 24;
  localparam step_t PLAN [NSTEP] = '{
    '{OP_TICKS, 8'd2,  1'b0, 8'd0},
    '{OP_RES,   8'd0,  1'b1, 8'd0},
    '{OP_RES,   8'd0,  1'b0, 8'd1},
    '{OP_TICKS, 8'd3,  1'b0, 8'd0},
    '{OP_RES,   8'd0,  1'b1, 8'd2},
    '{OP_WRITE, 8'd3,  1'b0, 8'd0},
    '{OP_RES,   8'd0,  1'b1, 8'd3},
    '{OP_RES,   8'd0,  1'b1, 8'd3},
    '{OP_TICKS, 8'd6,  1'b0, 8'd0},
    '{OP_RES,   8'd0,  1'b1, 8'd4},
    '{OP_WRRES, 8'd5,  1'b1, 8'd5},
    '{OP_RES,   8'd0,  1'b1, 8'd5},
    '{OP_RES,   8'd0,  1'b1, 8'd6},
    '{OP_RES,   8'd0,  1'b1, 8'd7},
    '{OP_TICKS, 8'd8,  1'b0, 8'd0},
    '{OP_WRITE, 8'd0,  1'b0, 8'd0},
    '{OP_WRITE, 8'd2,  1'b0, 8'd0},
    '{OP_RES,   8'd0,  1'b0, 8'd0},
    '{OP_RES,   8'd0,  1'b1, 8'd2},
    '{OP_TICKS, 8'd20, 1'b0, 8'd0},
    '{OP_RES,   8'd0,  1'b1, 8'd255},
    '{OP_WRITE, 8'd1,  1'b0, 8'd0},
    '{OP_RES,   8'd0,  1'b1, 8'd1},
    '{OP_TICKS, 8'd20, 1'b0, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [2:0] wr_row_i = '0;
  logic       res_valid_i = 1'b0;
  logic       res_pass_i = 1'b0;
  logic       ref_req_o, chk_req_o;
  logic [2:0] ref_row_o, chk_row_o;

  always #2.5 clk = ~clk;

  dr_refresh_sched #(.ROWS(ROWS), .HI_TICKS(HI), .LO_MULT(LMUL)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .wr_valid_i(wr_valid_i), .wr_row_i(wr_row_i),
    .res_valid_i(res_valid_i), .res_pass_i(res_pass_i),
    .ref_req_o(ref_req_o), .ref_row_o(ref_row_o),
    .chk_req_o(chk_req_o), .chk_row_o(chk_row_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model: 0 fresh, 1 faulty, 2 slow
  int cls      [ROWS];
  int deadline [ROWS];
  int last_ref [ROWS];
  bit demoted  [ROWS];
  int pend;
  bit stale;
  int tick_no;
  bit prev_ref;
  int prev_row;
  int ref_cnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic init_model();
    for (int r = 0; r < ROWS; r++) begin
      cls[r] = 0; deadline[r] = HI; last_ref[r] = 0; demoted[r] = 1'b0;
    end
    pend = -1; stale = 1'b0; tick_no = 0; prev_ref = 1'b0; prev_row = 0; ref_cnt = 0;
  endtask

  // monitor, sampling after the edge has settled
  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      if (ref_req_o) begin
        int r;
        string tag;
        r = int'(ref_row_o);
        tag = demoted[r] ? "R7" : ((cls[r] == 2) ? "R3" : "R2");
        chk(tick_no == deadline[r], tag, tick_no, deadline[r]);
        if (prev_ref) chk(r > prev_row, "R4", r, prev_row + 1);
        last_ref[r] = tick_no;
        deadline[r] = tick_no + ((cls[r] == 2) ? LO : HI);
        demoted[r]  = 1'b0;
        prev_row    = r;
        ref_cnt++;
      end
      prev_ref = ref_req_o;
      if (chk_req_o) begin
        int want;
        want = -1;
        for (int r = ROWS - 1; r >= 0; r--) if (cls[r] == 0) want = r;
        chk(pend < 0, "R8", pend, -1);
        chk(int'(chk_row_o) == want, "R8", int'(chk_row_o), want);
        pend  = int'(chk_row_o);
        stale = 1'b0;
      end
    end
  end

  task automatic apply_result(input bit pass);
    if (pend >= 0) begin
      if (!stale) begin
        cls[pend] = pass ? 2 : 1;
        if (pass) deadline[pend] = last_ref[pend] + LO;
      end
      pend  = -1;
      stale = 1'b0;
    end
  endtask

  task automatic do_tick();
    for (int r = 0; r < ROWS; r++)
      chk(deadline[r] > tick_no, "R3", tick_no, deadline[r]);
    @(negedge clk);
    tick_i = 1'b1;
    tick_no++;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_write(input int r, input bit with_res, input bit pass, input int exp);
    @(negedge clk);
    wr_valid_i = 1'b1;
    wr_row_i   = 3'(r);
    if (with_res) begin
      chk(pend == exp, "R9", pend, exp);
      res_valid_i = 1'b1;
      res_pass_i  = pass;
    end
    if (pend == r) stale = 1'b1;
    if (cls[r] == 2) begin
      deadline[r] = (tick_no > last_ref[r] + HI) ? tick_no : last_ref[r] + HI;
      demoted[r]  = 1'b1;
    end
    cls[r] = 0;
    if (with_res) apply_result(pass);
    @(negedge clk);
    wr_valid_i  = 1'b0;
    res_valid_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_result(input bit pass, input int exp);
    string tag;
    if (exp < 0)    tag = "R10";
    else if (stale) tag = "R9";
    else            tag = pass ? "R5" : "R6";
    chk(pend == exp, tag, pend, exp);
    @(negedge clk);
    res_valid_i = 1'b1;
    res_pass_i  = pass;
    apply_result(pass);
    @(negedge clk);
    res_valid_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    init_model();
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    chk(ref_req_o == 1'b0, "R1", int'(ref_req_o), 0);
    chk(chk_req_o == 1'b0, "R1", int'(chk_req_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      case (PLAN[i].op)
        OP_TICKS: for (int k = 0; k < int'(PLAN[i].arg); k++) do_tick();
        OP_WRITE: do_write(int'(PLAN[i].arg), 1'b0, 1'b0, 0);
        OP_RES:   do_result(PLAN[i].pass, (PLAN[i].exp == 8'd255) ? -1 : int'(PLAN[i].exp));
        default:  do_write(int'(PLAN[i].arg), 1'b1, PLAN[i].pass, int'(PLAN[i].exp));
      endcase
    end

    // Directed: reset in mid-run returns every row to the fast class (R1)
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ref_req_o == 1'b0, "R1", int'(ref_req_o), 0);
    chk(chk_req_o == 1'b0, "R1", int'(chk_req_o), 0);
    init_model();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < HI - 1; k++) do_tick();
    chk(ref_cnt == 0, "R1", ref_cnt, 0);
    do_tick();
    // R1 R4: a full burst of ROWS refreshes after HI ticks
    chk(ref_cnt == ROWS, "R1", ref_cnt, ROWS);
    for (int k = 0; k < HI; k++) do_tick();
    chk(ref_cnt == 2 * ROWS, "R2", ref_cnt, 2 * ROWS);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule